// File: doc/BRIEF.md
# Load-to-Use Stall Controller

This block sits at the decode stage of a five-stage, in-order integer pipeline. It checks whether the instruction now being decoded reads a register that a load, one stage further on, has not yet brought back from memory. Only the back-to-back case triggers a stall: the load is in execute and its consumer is in decode. Every longer distance is left to forwarding or to the register file, which writes in the first half of a cycle and reads in the second.

When the hazard is present, three things happen in the same cycle. The program counter and the fetch/decode register are told to hold. The control fields that enter the execute stage at the next edge are replaced by an all-zero no-op. The block owns that execute-stage control register (destination number, register-write, memory-read, memory-write). Its own execute-stage view is therefore always the one it compares against. Because a no-op then sits in execute, the hazard clears by itself one cycle later, and the held instruction goes on with the loaded value forwarded to it.

Every pin is a plain control signal with no handshake. The surrounding pipeline acts on `pc_write` and `ifid_write` in the cycle they are given.

Top module: `ldu_interlock`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `ex_rd` is 0 and `ex_reg_write`, `ex_mem_read` and `ex_mem_write` are 0. `pc_write` and `ifid_write` are 1 and `bubble` is 0, whatever the decode inputs.
- R2: When `ex_mem_read` is 1 and `ex_rd` is nonzero and equal to a decode source whose used flag is 1, `bubble` is 1 and `pc_write` and `ifid_write` are 0 in that same cycle.
- R3: Source slot 0 (`id_src[4:0]`) and source slot 1 (`id_src[9:5]`) each raise the stall on their own when they match.
- R4: A source whose used flag (`id_src_used[i]` for slot i) is 0 never causes a stall, even when its number equals `ex_rd`.
- R5: Register 0 is never a hazard: with `ex_rd` equal to 0, `bubble` stays 0 even when the execute instruction is a load.
- R6: An instruction in execute that is not a load (`ex_mem_read` 0) never causes a stall, even when its destination matches a used source.
- R7: At the clock edge that ends a stall cycle, all four execute-stage outputs become 0, whatever the decode control inputs were.
- R8: At the clock edge that ends a cycle without a stall, `ex_rd`, `ex_reg_write`, `ex_mem_read` and `ex_mem_write` take the values of `id_rd`, `id_reg_write`, `id_mem_read` and `id_mem_write`.
- R9: A stall lasts exactly one cycle. If the decode inputs are held through the stall, `bubble` is 0 in the next cycle.
- R10: When one instruction that is not a load sits between a load and its consumer, the consumer is not stalled.
- R11: `pc_write` and `ifid_write` are always equal, and both are the inverse of `bubble`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src | input | 10 | Two packed source register numbers of the instruction in decode; slot 0 in bits 4:0, slot 1 in bits 9:5 |
| id_src_used | input | 2 | Bit i is 1 when source slot i is actually read |
| id_rd | input | 5 | Destination register number of the instruction in decode |
| id_reg_write | input | 1 | Decode instruction writes a register |
| id_mem_read | input | 1 | Decode instruction is a load |
| id_mem_write | input | 1 | Decode instruction is a store |
| pc_write | output | 1 | 1 lets the program counter advance; 0 holds it |
| ifid_write | output | 1 | 1 lets the fetch/decode register load; 0 holds it |
| bubble | output | 1 | 1 when a no-op is being inserted into execute this cycle |
| ex_rd | output | 5 | Destination register of the instruction in execute |
| ex_reg_write | output | 1 | Execute instruction writes a register |
| ex_mem_read | output | 1 | Execute instruction is a load |
| ex_mem_write | output | 1 | Execute instruction is a store |

## Verification
The hardest thing to reach from the ports is a stall. It needs a load to be sitting in the execute register, and that register can only be filled by presenting the load on the decode inputs one cycle earlier. So every hazard case in the stimulus is a two-step sequence: a load first, then its consumer. The self-clearing of the stall is shown by holding the consumer's decode inputs unchanged through the stall. The next cycle must then show no stall, with the consumer's own fields in execute. A mid-run reset with a load still in execute shows that reset also removes a pending hazard.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Control flags carried from decode into execute.
  typedef struct packed {
    logic reg_write;
    logic mem_read;
    logic mem_write;
  } stage_ctrl_t;

  localparam stage_ctrl_t CTRL_NOP = '{reg_write: 1'b0, mem_read: 1'b0, mem_write: 1'b0};

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] src_i,
  input  logic [NSRC-1:0]         used_i,
  input  logic [AW-1:0]           dest_i,
  output logic [NSRC-1:0]         hit_o
);

  // One equality comparator per source slot, qualified by its used flag.
  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    assign hit_o[g] = used_i[g] && (src_i[g] == dest_i);
  end

endmodule

// File: rtl/hz_load_use_detect.sv
module hz_load_use_detect #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0] hit_i,
  input  logic            ex_is_load_i,
  input  logic [AW-1:0]   ex_dest_i,
  output logic            hazard_o
);

  logic dest_nonzero;
  logic any_hit;

  // Register 0 is hard-wired to zero, so writes to it never create a dependence.
  assign dest_nonzero = |ex_dest_i;
  assign any_hit      = |hit_i;
  assign hazard_o     = ex_is_load_i && dest_nonzero && any_hit;

endmodule

// File: rtl/hz_idex_ctrl.sv
module hz_idex_ctrl
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insert_nop_i,
  input  stage_ctrl_t id_ctrl_i,
  input  logic [AW-1:0] id_rd_i,
  output stage_ctrl_t ex_ctrl_o,
  output logic [AW-1:0] ex_rd_o
);

  // The register always advances; a stall replaces its contents with a no-op.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_ctrl_o <= CTRL_NOP;
      ex_rd_o   <= '0;
    end else if (insert_nop_i) begin
      ex_ctrl_o <= CTRL_NOP;
      ex_rd_o   <= '0;
    end else begin
      ex_ctrl_o <= id_ctrl_i;
      ex_rd_o   <= id_rd_i;
    end
  end

endmodule

// File: rtl/ldu_interlock.sv
module ldu_interlock
  import hz_pkg::*;
#(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC*AW-1:0]   id_src,
  input  logic [NSRC-1:0]      id_src_used,
  input  logic [AW-1:0]        id_rd,
  input  logic                 id_reg_write,
  input  logic                 id_mem_read,
  input  logic                 id_mem_write,
  output logic                 pc_write,
  output logic                 ifid_write,
  output logic                 bubble,
  output logic [AW-1:0]        ex_rd,
  output logic                 ex_reg_write,
  output logic                 ex_mem_read,
  output logic                 ex_mem_write
);

  logic [NSRC-1:0][AW-1:0] src_slots;
  logic [NSRC-1:0]         slot_hit;
  logic                    hazard;
  stage_ctrl_t             id_ctrl;
  stage_ctrl_t             ex_ctrl;

  assign src_slots = id_src;
  assign id_ctrl   = '{reg_write: id_reg_write, mem_read: id_mem_read, mem_write: id_mem_write};

  hz_src_match #(.AW(AW), .NSRC(NSRC)) u_match (
    .src_i  (src_slots),
    .used_i (id_src_used),
    .dest_i (ex_rd),
    .hit_o  (slot_hit)
  );

  hz_load_use_detect #(.AW(AW), .NSRC(NSRC)) u_detect (
    .hit_i        (slot_hit),
    .ex_is_load_i (ex_ctrl.mem_read),
    .ex_dest_i    (ex_rd),
    .hazard_o     (hazard)
  );

  hz_idex_ctrl #(.AW(AW)) u_idex (
    .clk          (clk),
    .rst_n        (rst_n),
    .insert_nop_i (hazard),
    .id_ctrl_i    (id_ctrl),
    .id_rd_i      (id_rd),
    .ex_ctrl_o    (ex_ctrl),
    .ex_rd_o      (ex_rd)
  );

  assign bubble       = hazard;
  assign pc_write     = ~hazard;
  assign ifid_write   = ~hazard;
  assign ex_reg_write = ex_ctrl.reg_write;
  assign ex_mem_read  = ex_ctrl.mem_read;
  assign ex_mem_write = ex_ctrl.mem_write;

endmodule

// File: rtl/ldu_interlock_chk.sv
module ldu_interlock_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pc_write,
  input logic          ifid_write,
  input logic          bubble,
  input logic [AW-1:0] id_rd,
  input logic          id_reg_write,
  input logic          id_mem_read,
  input logic          id_mem_write,
  input logic [AW-1:0] ex_rd,
  input logic          ex_reg_write,
  input logic          ex_mem_read,
  input logic          ex_mem_write
);

  // R9: a stall never lasts two cycles in a row
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !bubble);

  // R7: the edge after a stall leaves a no-op in execute
  a_r7_nop_fields: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (!ex_reg_write && !ex_mem_read && !ex_mem_write && ex_rd == '0));

  // R8: without a stall the decode fields move into execute
  a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble |=> (ex_rd == $past(id_rd) && ex_reg_write == $past(id_reg_write) &&
                 ex_mem_read == $past(id_mem_read) && ex_mem_write == $past(id_mem_write)));

  // R6: only a load in execute can stall
  a_r6_nonload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_read |-> !bubble);

  // R5: destination register 0 never stalls
  a_r5_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !bubble);

  // R11: both hold signals agree and oppose bubble
  a_r11_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_write == ifid_write) && (pc_write != bubble));

endmodule

bind ldu_interlock ldu_interlock_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pc_write     (pc_write),
  .ifid_write   (ifid_write),
  .bubble       (bubble),
  .id_rd        (id_rd),
  .id_reg_write (id_reg_write),
  .id_mem_read  (id_mem_read),
  .id_mem_write (id_mem_write),
  .ex_rd        (ex_rd),
  .ex_reg_write (ex_reg_write),
  .ex_mem_read  (ex_mem_read),
  .ex_mem_write (ex_mem_write)
);

// File: tb/ldu_interlock_tb_top.sv
module ldu_interlock_tb_top;

  localparam int AW   = 5;
  localparam int NSRC = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC*AW-1:0] id_src;
  logic [NSRC-1:0] id_src_used;
  logic [AW-1:0]   id_rd;
  logic            id_reg_write, id_mem_read, id_mem_write;
  logic            pc_write, ifid_write, bubble;
  logic [AW-1:0]   ex_rd;
  logic            ex_reg_write, ex_mem_read, ex_mem_write;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ldu_interlock #(.AW(AW), .NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_src(id_src), .id_src_used(id_src_used),
    .id_rd(id_rd), .id_reg_write(id_reg_write), .id_mem_read(id_mem_read),
    .id_mem_write(id_mem_write), .pc_write(pc_write), .ifid_write(ifid_write),
    .bubble(bubble), .ex_rd(ex_rd), .ex_reg_write(ex_reg_write),
    .ex_mem_read(ex_mem_read), .ex_mem_write(ex_mem_write)
  );

  typedef struct packed {
    logic [4:0] s0;
    logic       u0;
    logic [4:0] s1;
    logic       u1;
    logic [4:0] rd;
    logic       rw;
    logic       mr;
    logic       mw;
    logic       stall;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'd0, 1'b0, 5'd0, 1'b0, 5'd5,  1'b1, 1'b1, 1'b0, 1'b0}, // load r5
    '{5'd5, 1'b1, 5'd2, 1'b1, 5'd6,  1'b1, 1'b0, 1'b0, 1'b1}, // R2 R3 slot0 consumer stalls
    '{5'd5, 1'b1, 5'd2, 1'b1, 5'd6,  1'b1, 1'b0, 1'b0, 1'b0}, // R9 held consumer proceeds
    '{5'd6, 1'b1, 5'd0, 1'b0, 5'd7,  1'b1, 1'b1, 1'b0, 1'b0}, // R6 ALU result in EX, load r7
    '{5'd1, 1'b1, 5'd7, 1'b1, 5'd8,  1'b1, 1'b0, 1'b0, 1'b1}, // R3 slot1 consumer stalls
    '{5'd1, 1'b1, 5'd7, 1'b1, 5'd8,  1'b1, 1'b0, 1'b0, 1'b0}, // R9 held
    '{5'd0, 1'b0, 5'd0, 1'b0, 5'd9,  1'b1, 1'b1, 1'b0, 1'b0}, // load r9
    '{5'd9, 1'b0, 5'd9, 1'b0, 5'd10, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 unused sources
    '{5'd9, 1'b1, 5'd9, 1'b1, 5'd11, 1'b1, 1'b0, 1'b0, 1'b0}, // R10 one apart
    '{5'd0, 1'b0, 5'd0, 1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0}, // load to r0
    '{5'd0, 1'b1, 5'd0, 1'b1, 5'd12, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 r0 never stalls
    '{5'd0, 1'b0, 5'd0, 1'b0, 5'd3,  1'b1, 1'b1, 1'b0, 1'b0}, // load r3
    '{5'd3, 1'b1, 5'd3, 1'b1, 5'd0,  1'b0, 1'b1, 1'b1, 1'b1}, // R7 store+read fields cleared
    '{5'd3, 1'b1, 5'd3, 1'b1, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0}  // R9 held
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    id_src       = {v.s1, v.s0};
    id_src_used  = {v.u1, v.u0};
    id_rd        = v.rd;
    id_reg_write = v.rw;
    id_mem_read  = v.mr;
    id_mem_write = v.mw;
  endtask

  task automatic check_hold(input string tag, input logic exp_stall);
    check(tag, "bubble", 32'(bubble), 32'(exp_stall));
    check("R11", "pc_write", 32'(pc_write), 32'(!exp_stall));
    check("R11", "ifid_write", 32'(ifid_write), 32'(!exp_stall));
  endtask

  task automatic check_ex(input string tag, input logic [4:0] rd,
                          input logic rw, input logic mr, input logic mw);
    check(tag, "ex_rd", 32'(ex_rd), 32'(rd));
    check(tag, "ex_reg_write", 32'(ex_reg_write), 32'(rw));
    check(tag, "ex_mem_read", 32'(ex_mem_read), 32'(mr));
    check(tag, "ex_mem_write", 32'(ex_mem_write), 32'(mw));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    // Matching load-like inputs during reset must not leak through (R1).
    drive('{5'd4, 1'b1, 5'd4, 1'b1, 5'd4, 1'b1, 1'b1, 1'b1, 1'b0});
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_ex("R1", 5'd0, 1'b0, 1'b0, 1'b0);
    check_hold("R1", 1'b0);
    rst_n = 1'b1;
    #1;
    check_hold("R1", 1'b0);

    // Table walk: drive at the falling edge, check hold outputs, then EX after the rise.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1;
      check_hold(VECS[i].stall ? "R2" : "R9", VECS[i].stall);
      @(posedge clk);
      #1;
      if (VECS[i].stall)
        check_ex("R7", 5'd0, 1'b0, 1'b0, 1'b0);
      else
        check_ex("R8", VECS[i].rd, VECS[i].rw, VECS[i].mr, VECS[i].mw);
    end

    // R6: non-load producer with matching used source never stalls.
    @(negedge clk);
    drive('{5'd0, 1'b0, 5'd0, 1'b0, 5'd14, 1'b1, 1'b0, 1'b0, 1'b0});
    @(negedge clk);
    drive('{5'd14, 1'b1, 5'd14, 1'b1, 5'd15, 1'b1, 1'b0, 1'b0, 1'b0});
    #1;
    check_hold("R6", 1'b0);

    // R1: reset in the middle clears a pending hazard.
    @(negedge clk);
    drive('{5'd0, 1'b0, 5'd0, 1'b0, 5'd20, 1'b1, 1'b1, 1'b0, 1'b0});
    @(negedge clk);
    drive('{5'd20, 1'b1, 5'd0, 1'b0, 5'd21, 1'b1, 1'b0, 1'b0, 1'b0});
    #1;
    check_hold("R2", 1'b1);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check_ex("R1", 5'd0, 1'b0, 1'b0, 1'b0);
    check_hold("R1", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_hold("R1", 1'b0);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule